// File: doc/BRIEF.md
# High/Low/Edge Clock Divider

This block divides an input clock by an integer from 1 to 128. A divide value comes in with a write strobe. An encoder splits the value into a high-time count, a low-time count, an odd-ratio edge flag and a bypass flag, and packs these fields into two 16-bit configuration words. The two words are held in a shadow stage. They move into the active stage only when the running output period ends, so a reconfiguration never shortens or splits a period.

The divider counts input clock cycles against the active high and low times. When the ratio is odd, a flop on the falling edge stretches the high phase by half an input cycle, which keeps the duty cycle close to 50 %. A ratio of 1 bypasses the counter, and the input clock appears at the output unchanged. A read-back path rebuilds the divide value from the first shadow word by adding the low and high fields.

Top module: `hle_clk_divider`

## Requirements
- R1: For an accepted divide value N, the fields are high = floor(N/2), low = N - high and edge = N mod 2. The bypass flag is 1 only when N = 1.
- R2: Word A holds high in bits 11:6 and low in bits 5:0. Bits 15:12 are zero. A field value of 64 is stored as 0, so N = 127 gives 0x0FC0 and N = 128 gives 0x0000.
- R3: Word B holds edge in bit 7 and the bypass flag in bit 6. All other bits are zero. N = 1 gives 0x00C0, any other odd N gives 0x0080, and even N gives 0x0000.
- R4: From the clock edge that accepts a write onward, `rd_div` equals decoded low plus decoded high of word A. A low field of 0 decodes as 64. A high field of 0 decodes as 64 only when the low field is also 0. The result equals the N that was written.
- R5: Only values from 1 to 128 are accepted. A write of 0 or of any value above 128 leaves both words, `rd_div` and the output clock unchanged.
- R6: For N > 1, each output period is high for 2*high + edge input half-cycles and low for 2*low - edge input half-cycles.
- R7: For N = 1, `clk_out` follows the input clock: high for one half-cycle and low for one half-cycle.
- R8: During reset and after it, until the first accepted configuration takes effect, `clk_out` is low, both words are zero and `rd_div` is zero.
- R9: A configuration written during an output period takes effect only when that period ends. The current period completes with its old high and low times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; also clocks the configuration logic |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for a new divide value |
| cfg_div | input | DIV_W (8) | Divide value, accepted when it lies in 1..128 |
| div_word_a | output | 16 | Shadow word A: high and low time fields |
| div_word_b | output | 16 | Shadow word B: edge flag and bypass flag |
| rd_div | output | DIV_W (8) | Divide value rebuilt from word A, 0 before the first accepted write |
| clk_out | output | 1 | Divided clock |

## Verification
The bound checker watches the following on every cycle:
- the cleared state after reset;
- the fixed shape of word B and the zero upper bits of word A;
- read-back of each accepted value and the edge bit;
- that rejected writes leave the words stable;
- that the active configuration never changes before the end of an output period.

The output waveform cannot be seen by a property sampled at one clock edge, because it is built from both edges. The bench therefore counts high and low half-cycles of `clk_out` for each ratio in its table, for the clock pass-through at N = 1, and for a reconfiguration made in the middle of a period.

// File: rtl/hle_div_pkg.sv
`timescale 1ns/1ps
// Package: field geometry of the two configuration words and the decode
// rules shared by the divider core, the read-back path and the checker.
// Assumes six-bit time fields, where the value 64 is stored as zero.
package hle_div_pkg;

    localparam int unsigned FIELD_W   = 6;
    localparam int unsigned WORD_W    = 16;
    localparam int unsigned SPAN_W    = FIELD_W + 1;
    localparam int unsigned LO_LSB    = 0;
    localparam int unsigned HI_LSB    = FIELD_W;
    localparam int unsigned NOCNT_BIT = 6;
    localparam int unsigned EDGE_BIT  = 7;
    localparam int unsigned MAX_DIV   = 2 * (2 ** FIELD_W);

    // Low field: zero stands for the full span 2**FIELD_W.
    function automatic logic [SPAN_W-1:0] decode_low(input logic [FIELD_W-1:0] lo_f);
        return (lo_f == '0) ? SPAN_W'(2 ** FIELD_W) : {1'b0, lo_f};
    endfunction

    // High field: zero means the full span only when low is also zero.
    function automatic logic [SPAN_W-1:0] decode_high(input logic [FIELD_W-1:0] hi_f,
                                                      input logic [FIELD_W-1:0] lo_f);
        return (hi_f == '0 && lo_f == '0) ? SPAN_W'(2 ** FIELD_W) : {1'b0, hi_f};
    endfunction

endpackage

// File: rtl/hle_encoder.sv
`timescale 1ns/1ps
// Module: hle_encoder
// Turns an integer divide value into the high/low/edge/bypass fields and
// packs them into the two configuration words. Purely combinational.
// Assumes DIV_W is wide enough to hold MAX_DIV.
module hle_encoder
    import hle_div_pkg::*;
#(
    parameter int unsigned DIV_W = FIELD_W + 2
) (
    input  logic [DIV_W-1:0]  div_in,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic              accept
);

    logic [FIELD_W-1:0] hi_f;
    logic [FIELD_W-1:0] lo_f;

    // Field split: high is half the ratio, low adds the odd remainder.
    always_comb begin
        hi_f   = div_in[FIELD_W:1];
        lo_f   = hi_f + FIELD_W'(div_in[0]);
        accept = (div_in != '0) && (div_in <= DIV_W'(MAX_DIV));
    end

    // Word packing at the fixed field positions.
    always_comb begin
        word_a                      = '0;
        word_a[HI_LSB +: FIELD_W]   = hi_f;
        word_a[LO_LSB +: FIELD_W]   = lo_f;
        word_b                      = '0;
        word_b[EDGE_BIT]            = div_in[0];
        word_b[NOCNT_BIT]           = (div_in == DIV_W'(1));
    end

endmodule

// File: rtl/hle_cfg_store.sv
`timescale 1ns/1ps
// Module: hle_cfg_store
// Holds the shadow configuration words written by software and the active
// field set used by the divider. The shadow moves to the active stage when
// the divider is idle or at the end of an output period.
// Assumes at_last is high for exactly one cycle per output period.
module hle_cfg_store
    import hle_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic [WORD_W-1:0]  in_a,
    input  logic [WORD_W-1:0]  in_b,
    input  logic               at_last,
    output logic [WORD_W-1:0]  sh_a,
    output logic [WORD_W-1:0]  sh_b,
    output logic               sh_vld,
    output logic [FIELD_W-1:0] act_hi,
    output logic [FIELD_W-1:0] act_lo,
    output logic               act_edge,
    output logic               act_nc,
    output logic               act_vld,
    output logic [FIELD_W-1:0] nxt_hi,
    output logic [FIELD_W-1:0] nxt_lo,
    output logic               nxt_nc,
    output logic               nxt_vld,
    output logic               load
);

    logic pend;

    // Transfer condition: something new is waiting and the period is done.
    always_comb begin
        load = pend && (!act_vld || at_last);
    end

    // Fields that will be active after the coming edge.
    always_comb begin
        nxt_hi  = load ? sh_a[HI_LSB +: FIELD_W] : act_hi;
        nxt_lo  = load ? sh_a[LO_LSB +: FIELD_W] : act_lo;
        nxt_nc  = load ? sh_b[NOCNT_BIT]         : act_nc;
        nxt_vld = load | act_vld;
    end

    // Shadow capture and pending flag; a write on a load edge stays pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_a   <= '0;
            sh_b   <= '0;
            sh_vld <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (wr_ok) begin
                sh_a   <= in_a;
                sh_b   <= in_b;
                sh_vld <= 1'b1;
            end
            pend <= wr_ok ? 1'b1 : (load ? 1'b0 : pend);
        end
    end

    // Active field set, updated only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi   <= '0;
            act_lo   <= '0;
            act_edge <= 1'b0;
            act_nc   <= 1'b0;
            act_vld  <= 1'b0;
        end else if (load) begin
            act_hi   <= sh_a[HI_LSB +: FIELD_W];
            act_lo   <= sh_a[LO_LSB +: FIELD_W];
            act_edge <= sh_b[EDGE_BIT];
            act_nc   <= sh_b[NOCNT_BIT];
            act_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/hle_div_core.sv
`timescale 1ns/1ps
// Module: hle_div_core
// Counts input cycles against the active high and low times. A rising-edge
// flop gives the high phase, and a falling-edge copy stretches it by half a
// cycle for odd ratios. In bypass mode the input clock passes straight out.
// Assumes the high and low fields change only on load edges.
module hle_div_core
    import hle_div_pkg::*;
#(
    parameter int unsigned CNT_W = SPAN_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] act_hi,
    input  logic [FIELD_W-1:0] act_lo,
    input  logic               act_edge,
    input  logic               act_nc,
    input  logic               act_vld,
    input  logic [FIELD_W-1:0] nxt_hi,
    input  logic [FIELD_W-1:0] nxt_lo,
    input  logic               nxt_nc,
    input  logic               nxt_vld,
    input  logic               load,
    output logic               at_last,
    output logic               clk_out
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt_cnt;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] nxt_high;
    logic             q_pos;
    logic             q_neg;

    // Period end index from the decoded active times.
    always_comb begin
        last_idx = CNT_W'(decode_low(act_lo)) + CNT_W'(decode_high(act_hi, act_lo)) - CNT_W'(1);
        at_last  = act_vld && (cnt == last_idx);
        nxt_high = CNT_W'(decode_high(nxt_hi, nxt_lo));
    end

    // Next count: restart on a load or at the period end.
    always_comb begin
        if (load || !act_vld || at_last) begin
            nxt_cnt = '0;
        end else begin
            nxt_cnt = cnt + CNT_W'(1);
        end
    end

    // Rising-edge phase counter and high-phase flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            q_pos <= 1'b0;
        end else begin
            cnt   <= nxt_cnt;
            q_pos <= nxt_vld && !nxt_nc && (nxt_cnt < nxt_high);
        end
    end

    // Falling-edge copy of the high phase for the half-cycle stretch.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q_neg <= 1'b0;
        end else begin
            q_neg <= q_pos;
        end
    end

    // Output select: bypass passes the clock, else the stretched phase.
    always_comb begin
        if (act_vld && act_nc) begin
            clk_out = clk;
        end else begin
            clk_out = q_pos | (act_edge & q_neg);
        end
    end

endmodule

// File: rtl/hle_readback.sv
`timescale 1ns/1ps
// Module: hle_readback
// Rebuilds the divide value from the low and high fields of word A.
// Returns zero until a configuration has been accepted.
module hle_readback
    import hle_div_pkg::*;
#(
    parameter int unsigned DIV_W = FIELD_W + 2
) (
    input  logic [FIELD_W-1:0] hi_f,
    input  logic [FIELD_W-1:0] lo_f,
    input  logic               vld,
    output logic [DIV_W-1:0]   div_out
);

    // Sum of decoded fields, gated by validity.
    always_comb begin
        if (vld) begin
            div_out = DIV_W'(decode_low(lo_f)) + DIV_W'(decode_high(hi_f, lo_f));
        end else begin
            div_out = '0;
        end
    end

endmodule

// File: rtl/hle_clk_divider.sv
`timescale 1ns/1ps
// Module: hle_clk_divider (top)
// Programmable high/low/edge clock divider. It has an encoder, a shadow and
// active configuration store, the divider core and the read-back path.
// Assumes cfg_wr and cfg_div are synchronous to clk.
module hle_clk_divider
    import hle_div_pkg::*;
#(
    parameter int unsigned DIV_W = FIELD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic [WORD_W-1:0] div_word_a,
    output logic [WORD_W-1:0] div_word_b,
    output logic [DIV_W-1:0]  rd_div,
    output logic              clk_out
);

    localparam int unsigned CNT_W = SPAN_W + 1;

    logic [WORD_W-1:0]  enc_a;
    logic [WORD_W-1:0]  enc_b;
    logic               enc_ok;
    logic               wr_ok;
    logic               sh_vld;
    logic [FIELD_W-1:0] act_hi;
    logic [FIELD_W-1:0] act_lo;
    logic               act_edge;
    logic               act_nc;
    logic               act_vld;
    logic [FIELD_W-1:0] nxt_hi;
    logic [FIELD_W-1:0] nxt_lo;
    logic               nxt_nc;
    logic               nxt_vld;
    logic               load;
    logic               at_last;

    // Write qualification: strobe and legal range.
    always_comb begin
        wr_ok = cfg_wr && enc_ok;
    end

    hle_encoder #(.DIV_W(DIV_W)) u_enc (
        .div_in (cfg_div),
        .word_a (enc_a),
        .word_b (enc_b),
        .accept (enc_ok)
    );

    hle_cfg_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .in_a     (enc_a),
        .in_b     (enc_b),
        .at_last  (at_last),
        .sh_a     (div_word_a),
        .sh_b     (div_word_b),
        .sh_vld   (sh_vld),
        .act_hi   (act_hi),
        .act_lo   (act_lo),
        .act_edge (act_edge),
        .act_nc   (act_nc),
        .act_vld  (act_vld),
        .nxt_hi   (nxt_hi),
        .nxt_lo   (nxt_lo),
        .nxt_nc   (nxt_nc),
        .nxt_vld  (nxt_vld),
        .load     (load)
    );

    hle_div_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_hi   (act_hi),
        .act_lo   (act_lo),
        .act_edge (act_edge),
        .act_nc   (act_nc),
        .act_vld  (act_vld),
        .nxt_hi   (nxt_hi),
        .nxt_lo   (nxt_lo),
        .nxt_nc   (nxt_nc),
        .nxt_vld  (nxt_vld),
        .load     (load),
        .at_last  (at_last),
        .clk_out  (clk_out)
    );

    hle_readback #(.DIV_W(DIV_W)) u_rb (
        .hi_f    (div_word_a[HI_LSB +: FIELD_W]),
        .lo_f    (div_word_a[LO_LSB +: FIELD_W]),
        .vld     (sh_vld),
        .div_out (rd_div)
    );

endmodule

// File: rtl/hle_clk_divider_chk.sv
`timescale 1ns/1ps
// Module: hle_clk_divider_chk
// Property checker bound to hle_clk_divider. It watches the configuration
// words, the read-back value and the hold of the active field set.
module hle_clk_divider_chk
    import hle_div_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic [7:0]         cfg_div,
    input logic [WORD_W-1:0]  div_word_a,
    input logic [WORD_W-1:0]  div_word_b,
    input logic [7:0]         rd_div,
    input logic [FIELD_W-1:0] act_hi,
    input logic [FIELD_W-1:0] act_lo,
    input logic               act_edge,
    input logic               act_nc,
    input logic               act_vld,
    input logic               at_last
);

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (div_word_a == '0 && div_word_b == '0 && rd_div == '0 && !act_vld));

    assert_bad_value_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_div == '0 || cfg_div > 8'(MAX_DIV)))
        |=> ($stable(div_word_a) && $stable(div_word_b) && $stable(rd_div)));

    assert_readback_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_div != '0 && cfg_div <= 8'(MAX_DIV)) |=> (rd_div == $past(cfg_div)));

    assert_edge_is_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_div != '0 && cfg_div <= 8'(MAX_DIV)) |=> (div_word_b[EDGE_BIT] == $past(cfg_div[0])));

    assert_word_a_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_word_a[WORD_W-1:2*FIELD_W] == '0);

    assert_word_b_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_word_b & ~((WORD_W'(1) << EDGE_BIT) | (WORD_W'(1) << NOCNT_BIT))) == '0)
        && (!div_word_b[NOCNT_BIT] || div_word_b[EDGE_BIT]));

    assert_hold_until_period_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld && !at_last)
        |=> ($stable(act_hi) && $stable(act_lo) && $stable(act_edge) && $stable(act_nc)));

endmodule

bind hle_clk_divider hle_clk_divider_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_div    (cfg_div),
    .div_word_a (div_word_a),
    .div_word_b (div_word_b),
    .rd_div     (rd_div),
    .act_hi     (act_hi),
    .act_lo     (act_lo),
    .act_edge   (act_edge),
    .act_nc     (act_nc),
    .act_vld    (act_vld),
    .at_last    (at_last)
);

// File: tb/tb_hle_clk_divider.sv
`timescale 1ns/1ps
// Bench for hle_clk_divider. It samples clk_out at quarter points of every
// half-cycle and counts high and low half-cycles per output period.
module tb_hle_clk_divider;

    localparam int PERIOD = 10;
    localparam int NVEC   = 11;

    localparam logic [7:0]  VDIV [0:NVEC-1] = '{8'd2, 8'd3, 8'd4, 8'd5, 8'd7, 8'd8,
                                                8'd33, 8'd64, 8'd127, 8'd128, 8'd1};
    localparam logic [15:0] VWA  [0:NVEC-1] = '{16'h0041, 16'h0042, 16'h0082, 16'h0083,
                                                16'h00C4, 16'h0104, 16'h0411, 16'h0820,
                                                16'h0FC0, 16'h0000, 16'h0001};
    localparam logic [15:0] VWB  [0:NVEC-1] = '{16'h0000, 16'h0080, 16'h0000, 16'h0080,
                                                16'h0080, 16'h0000, 16'h0080, 16'h0000,
                                                16'h0080, 16'h0000, 16'h00C0};

    logic        clk;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_div;
    logic [15:0] div_word_a;
    logic [15:0] div_word_b;
    logic [7:0]  rd_div;
    logic        clk_out;

    int checks = 0;
    int errors = 0;
    bit ph;
    bit cur;

    hle_clk_divider dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_div    (cfg_div),
        .div_word_a (div_word_a),
        .div_word_b (div_word_b),
        .rd_div     (rd_div),
        .clk_out    (clk_out)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance one half-cycle; ph=1 means just after a rising edge.
    task automatic half();
        #(PERIOD/2);
        ph  = !ph;
        cur = clk_out;
    endtask

    task automatic halves(input int n);
        for (int i = 0; i < n; i++) half();
    endtask

    // Present a write across exactly one rising edge.
    task automatic write_div(input logic [7:0] v);
        while (ph != 1'b0) half();
        cfg_wr  = 1'b1;
        cfg_div = v;
        half();
        cfg_wr  = 1'b0;
    endtask

    task automatic sync_rise(output bit ok);
        bit prev;
        ok   = 1'b0;
        prev = cur;
        for (int i = 0; i < 1200; i++) begin
            half();
            if (!prev && cur) begin
                ok = 1'b1;
                break;
            end
            prev = cur;
        end
    endtask

    // Count one high run then one low run, starting at a high sample.
    task automatic run_lengths(inout int hi, output int lo);
        for (int i = 0; i < 600 && cur; i++) begin hi++; half(); end
        lo = 0;
        for (int i = 0; i < 600 && !cur; i++) begin lo++; half(); end
    endtask

    task automatic measure(output int hi, output int lo);
        bit ok;
        sync_rise(ok);
        hi = 0;
        lo = 0;
        if (ok) run_lengths(hi, lo);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hi;
        int lo;
        int seen_high;
        rst_n   = 1'b0;
        cfg_wr  = 1'b0;
        cfg_div = 8'd0;
        @(posedge clk);
        #(PERIOD/4);
        ph  = 1'b1;
        cur = clk_out;
        halves(6);

        // R8: reset state
        chk("R8", "clk_out in reset", int'(cur), 0);
        chk("R8", "word A in reset", int'(div_word_a), 0);
        chk("R8", "word B in reset", int'(div_word_b), 0);
        chk("R8", "rd_div in reset", int'(rd_div), 0);
        while (ph != 1'b0) half();
        rst_n = 1'b1;
        seen_high = 0;
        for (int i = 0; i < 40; i++) begin half(); if (cur) seen_high++; end
        chk("R8", "clk_out highs before config", seen_high, 0);
        chk("R8", "rd_div before config", int'(rd_div), 0);

        // Table walk: R1 R2 R3 R4 R6 R7
        for (int k = 0; k < NVEC; k++) begin
            int n;
            int h;
            int l;
            int e;
            n = int'(VDIV[k]);
            h = n / 2;
            l = n - h;
            e = n % 2;
            write_div(VDIV[k]);
            chk("R2", $sformatf("word A N=%0d", n), int'(div_word_a), int'(VWA[k]));
            chk("R3", $sformatf("word B N=%0d", n), int'(div_word_b), int'(VWB[k]));
            chk("R1", $sformatf("high field N=%0d", n), int'(div_word_a[11:6]), h % 64);
            chk("R4", $sformatf("rd_div N=%0d", n), int'(rd_div), n);
            halves(270);
            measure(hi, lo);
            if (n == 1) begin
                chk("R7", "pass-through high halves", hi, 1);
                chk("R7", "pass-through low halves", lo, 1);
            end else begin
                chk("R6", $sformatf("high halves N=%0d", n), hi, 2 * h + e);
                chk("R6", $sformatf("low halves N=%0d", n), lo, 2 * l - e);
            end
        end

        // R5: illegal values leave words, read-back and output untouched
        write_div(8'd5);
        halves(270);
        write_div(8'd0);
        chk("R5", "word A after 0", int'(div_word_a), 16'h0083);
        chk("R5", "rd_div after 0", int'(rd_div), 5);
        write_div(8'd129);
        chk("R5", "word B after 129", int'(div_word_b), 16'h0080);
        write_div(8'd200);
        chk("R5", "rd_div after 200", int'(rd_div), 5);
        halves(270);
        measure(hi, lo);
        chk("R5", "high halves kept", hi, 5);
        chk("R5", "low halves kept", lo, 5);

        // R9: write N=2 just after a rise of an N=16 period
        write_div(8'd16);
        halves(300);
        begin
            bit ok;
            sync_rise(ok);
            chk("R9", "sync found", int'(ok), 1);
            hi = 0;
            if (cur) hi++;
            half();
            if (cur) hi++;
            cfg_wr  = 1'b1;
            cfg_div = 8'd2;
            half();
            cfg_wr  = 1'b0;
            chk("R9", "rd_div updated at once", int'(rd_div), 2);
            run_lengths(hi, lo);
            chk("R9", "old high kept", hi, 16);
            chk("R9", "old low kept", lo, 16);
            hi = 0;
            run_lengths(hi, lo);
            chk("R9", "new high after boundary", hi, 2);
            chk("R9", "new low after boundary", lo, 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule